// File: doc/BRIEF.md
# Masked Alarm and Interrupt Combiner

This block sits beside a running time-of-day counter and watches four BCD fields of it: seconds, minutes, hours and day of month. A software-visible alarm register holds a target for each field, and the top bit of each alarm register is a mask bit. Together the four mask bits choose how often the alarm fires, from once every second up to one specific date and time. On each one-second tick the block compares the freshly advanced time against the unmasked targets. On a hit it latches an alarm flag.

Three interrupt sources share one active-low open-drain interrupt pin:
- the latched alarm flag, gated by an enable bit;
- a watchdog-expiry flag raised by a neighbouring watchdog counter;
- a 512 Hz oscillator test square wave.

In battery-backup mode the alarm reaches the pin only if a second, backup-specific enable is also set. In that mode all register accesses are ignored.

Software clears a pending interrupt by holding the flag register's address during an access. The pin releases at once. The flag bits drop at the clock edge that follows the end of that access.

Top module: `alarm_irq_unit`

## Requirements
- R1: After synchronous reset, the alarm enable, backup enable, alarm flag and watchdog flag are all 0. The interrupt pin is released (`irq_od_n` = 1), and reads of address 0h and 6h return 00h.
- R2: Alarm registers sit at 2h (seconds), 3h (minutes), 4h (hours) and 5h (date). Bit 7 of each is the mask bit M0 to M3 respectively. With the pattern written {M3,M2,M1,M0}, the match rules are:
  - 1111: every tick.
  - 1110: seconds bits [6:0] equal.
  - 1100: seconds and minutes bits [6:0] equal.
  - 1000: seconds, minutes and hours (bits [5:0]) equal.
  - 0000: all four fields equal, with date compared on bits [5:0].
- R3: Every other mask pattern fires on every tick.
- R4: The alarm flag is set only at a clock edge where `tick` is high and the fields match. It is visible in the following cycle. A matching time without a tick sets nothing.
- R5: When the alarm flag is set and AE is set, the pin is pulled low (`irq_od_n` = 0). AE is bit 7 of 6h. While `backup` is high, the alarm also needs ABE, which is bit 5 of 6h.
- R6: A read of 0h returns the watchdog flag in bit 7, the alarm flag in bit 6 and `bat_low` in bit 4. Bits 5 and 3..0 read 0. A write to 0h changes nothing.
- R7: While an access holds address 0h, the alarm and watchdog sources are masked off the pin. Both flags clear at the first edge after that access ends.
- R8: When a matching tick falls on the same edge as that clear, the alarm flag stays set.
- R9: A `wdog_expire` pulse sets the watchdog flag. The flag pulls the pin low only while `wds` is 0.
- R10: With `ft_en` = 1, AE = 0, and either `wds` or `wdog_zero` high, the pin follows the 512 Hz input: it is low while `osc_512` is high. Otherwise the test source is off.
- R11: While `backup` is high, writes are ignored and a flag-address access clears nothing.
- R12: Register 6h stores and returns all eight bits written. Alarm registers read back as written. Addresses other than 0h and 2h..6h read 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle strobe after the time fields have advanced one second |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD 24-hour |
| cur_date | input | 8 | Current day of month, BCD |
| acc_active | input | 1 | Register access in progress (level) |
| acc_wr | input | 1 | Access is a write |
| acc_addr | input | 4 | Register address |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data for `acc_addr` |
| backup | input | 1 | Battery-backup mode |
| bat_low | input | 1 | Battery-low status, reported in the flag register |
| wdog_expire | input | 1 | Watchdog expiry pulse |
| wds | input | 1 | Watchdog steering bit (1 = watchdog kept off the pin) |
| wdog_zero | input | 1 | Watchdog register holds 00h |
| ft_en | input | 1 | Frequency-test enable bit |
| osc_512 | input | 1 | 512 Hz square wave from the oscillator divider |
| irq_od_n | output | 1 | Open-drain pull-down enable, 0 = pin pulled low |

## Verification
Two functions can land on the same edge: a matching one-second tick that sets the alarm flag, and the end of a flag-register access that clears it. The bench provokes this by holding address 0h for one cycle. On the very next cycle it drops the access and raises `tick` under an every-second mask, so both act at one edge. It then reads the flag register and expects bit 6 still set. Constrained-random rounds with random mask patterns, including illegal ones, and partly matching times judge the match rules against a bench model.

// File: rtl/alarm_pkg.sv
// alarm_pkg: shared constants, rate type and helpers for the alarm/interrupt unit.
// Assumes 8-bit registers and a 4-bit register address.
package alarm_pkg;

    localparam int NUM_FIELDS   = 4;   // seconds, minutes, hours, date
    localparam int ADR_FLAGS    = 0;
    localparam int ADR_ALM_BASE = 2;   // seconds alarm, then min, hour, date
    localparam int ADR_IRQ_CTL  = 6;

    localparam int MASK_BIT   = 7;     // mask bit inside each alarm field
    localparam int AE_BIT     = 7;
    localparam int ABE_BIT    = 5;
    localparam int WF_BIT     = 7;
    localparam int AF_BIT     = 6;
    localparam int BLF_BIT    = 4;

    typedef enum logic [2:0] {
        RATE_EVERY,
        RATE_SEC,
        RATE_MIN_SEC,
        RATE_HR_MIN_SEC,
        RATE_FULL
    } alarm_rate_e;

    // Map the mask pattern {M3,M2,M1,M0} to an alarm rate; unknown -> every tick.
    function automatic alarm_rate_e decode_rate(input logic [NUM_FIELDS-1:0] am);
        case (am)
            4'b1110: decode_rate = RATE_SEC;
            4'b1100: decode_rate = RATE_MIN_SEC;
            4'b1000: decode_rate = RATE_HR_MIN_SEC;
            4'b0000: decode_rate = RATE_FULL;
            default: decode_rate = RATE_EVERY;
        endcase
    endfunction

    // Significant compare bits of each BCD field.
    function automatic logic [7:0] field_cmp_mask(input int idx);
        field_cmp_mask = (idx < 2) ? 8'h7F : 8'h3F;
    endfunction

endpackage

// File: rtl/alarm_match.sv
// alarm_match: compares current BCD time fields with alarm targets under the
// per-field mask bits. Purely combinational; the caller qualifies with tick.
module alarm_match
    import alarm_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [NUM_FIELDS-1:0][DW-1:0] alm_fields,
    input  logic [NUM_FIELDS-1:0][DW-1:0] cur_fields,
    output logic                          match
);

    logic [NUM_FIELDS-1:0] field_eq;
    logic [NUM_FIELDS-1:0] mask_bits;
    alarm_rate_e           rate;

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_cmp
        // Per-field equality over the significant BCD bits only.
        assign field_eq[g]  = ((alm_fields[g] ^ cur_fields[g]) & field_cmp_mask(g)) == '0;
        assign mask_bits[g] = alm_fields[g][MASK_BIT];
    end

    assign rate = decode_rate(mask_bits);

    // Select how many fields must agree for the chosen rate.
    always_comb begin
        case (rate)
            RATE_SEC:        match = field_eq[0];
            RATE_MIN_SEC:    match = &field_eq[1:0];
            RATE_HR_MIN_SEC: match = &field_eq[2:0];
            RATE_FULL:       match = &field_eq;
            default:         match = 1'b1;
        endcase
    end

endmodule

// File: rtl/alarm_regs.sv
// alarm_regs: alarm target registers, interrupt-control register, and the
// alarm/watchdog flags with their end-of-access clear. Accesses are level
// qualified by acc_active and ignored in backup mode.
module alarm_regs
    import alarm_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          acc_active,
    input  logic                          acc_wr,
    input  logic [AW-1:0]                 acc_addr,
    input  logic [DW-1:0]                 acc_wdata,
    input  logic                          backup,
    input  logic                          bat_low,
    input  logic                          tick,
    input  logic                          match,
    input  logic                          wdog_expire,
    output logic [DW-1:0]                 rdata,
    output logic [NUM_FIELDS-1:0][DW-1:0] alm_fields,
    output logic                          ae,
    output logic                          abe,
    output logic                          af,
    output logic                          wf,
    output logic                          flags_hold
);

    logic          acc_ok;
    logic          wr_en;
    logic          hold_q;
    logic          clear_pulse;
    logic [DW-1:0] ctl_q;
    logic [DW-1:0] fld_q [NUM_FIELDS];
    logic [DW-1:0] flags_rd;

    assign acc_ok      = acc_active && !backup;
    assign wr_en       = acc_ok && acc_wr;
    assign flags_hold  = acc_ok && (acc_addr == AW'(ADR_FLAGS));
    assign clear_pulse = hold_q && !flags_hold;

    // Remember that the flag address was held, to detect the end of access.
    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= 1'b0;
        else        hold_q <= flags_hold;
    end

    // Alarm flag: set on a matching tick, which wins over the access clear.
    always_ff @(posedge clk) begin
        if (!rst_n)              af <= 1'b0;
        else if (tick && match)  af <= 1'b1;
        else if (clear_pulse)    af <= 1'b0;
    end

    // Watchdog flag: set on expiry, cleared at the end of a flag access.
    always_ff @(posedge clk) begin
        if (!rst_n)            wf <= 1'b0;
        else if (wdog_expire)  wf <= 1'b1;
        else if (clear_pulse)  wf <= 1'b0;
    end

    // Interrupt-control register: all bits stored, AE/ABE decoded below.
    always_ff @(posedge clk) begin
        if (!rst_n)                                       ctl_q <= '0;
        else if (wr_en && acc_addr == AW'(ADR_IRQ_CTL))   ctl_q <= acc_wdata;
    end

    assign ae  = ctl_q[AE_BIT];
    assign abe = ctl_q[ABE_BIT];

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
        // One alarm target register per time field.
        always_ff @(posedge clk) begin
            if (!rst_n)                                          fld_q[g] <= '0;
            else if (wr_en && acc_addr == AW'(ADR_ALM_BASE + g)) fld_q[g] <= acc_wdata;
        end
        assign alm_fields[g] = fld_q[g];
    end

    // Assemble the read-only flag register; unused bits stay zero.
    always_comb begin
        flags_rd          = '0;
        flags_rd[WF_BIT]  = wf;
        flags_rd[AF_BIT]  = af;
        flags_rd[BLF_BIT] = bat_low;
    end

    // Read mux over the registers owned here; others read as zero.
    always_comb begin
        rdata = '0;
        if (acc_addr == AW'(ADR_FLAGS))   rdata = flags_rd;
        if (acc_addr == AW'(ADR_IRQ_CTL)) rdata = ctl_q;
        for (int i = 0; i < NUM_FIELDS; i++) begin
            if (acc_addr == AW'(ADR_ALM_BASE + i)) rdata = fld_q[i];
        end
    end

endmodule

// File: rtl/irq_combine.sv
// irq_combine: merges alarm, watchdog and 512 Hz test sources onto one
// active-low open-drain enable. Combinational; assumes registered flags.
module irq_combine (
    input  logic af,
    input  logic ae,
    input  logic abe,
    input  logic backup,
    input  logic wf,
    input  logic wds,
    input  logic ft_en,
    input  logic wdog_zero,
    input  logic osc_512,
    input  logic flags_hold,
    output logic irq_od_n
);

    logic alarm_src;
    logic wd_src;
    logic ft_src;

    // Alarm needs AE; in backup it also needs ABE; masked during flag access.
    assign alarm_src = af && ae && (!backup || abe) && !flags_hold;
    // Watchdog reaches the pin only when steered to it.
    assign wd_src    = wf && !wds && !flags_hold;
    // Test square wave when enabled, alarm off, watchdog steered or idle.
    assign ft_src    = ft_en && !ae && (wds || wdog_zero) && osc_512;

    assign irq_od_n  = !(alarm_src || wd_src || ft_src);

endmodule

// File: rtl/alarm_irq_unit.sv
// alarm_irq_unit: top of the masked alarm and interrupt logic. Assumes the
// time fields are stable and already advanced in the cycle tick is high.
module alarm_irq_unit
    import alarm_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [DW-1:0] cur_sec,
    input  logic [DW-1:0] cur_min,
    input  logic [DW-1:0] cur_hour,
    input  logic [DW-1:0] cur_date,
    input  logic          acc_active,
    input  logic          acc_wr,
    input  logic [AW-1:0] acc_addr,
    input  logic [DW-1:0] acc_wdata,
    output logic [DW-1:0] acc_rdata,
    input  logic          backup,
    input  logic          bat_low,
    input  logic          wdog_expire,
    input  logic          wds,
    input  logic          wdog_zero,
    input  logic          ft_en,
    input  logic          osc_512,
    output logic          irq_od_n
);

    logic [NUM_FIELDS-1:0][DW-1:0] alm_fields;
    logic [NUM_FIELDS-1:0][DW-1:0] cur_fields;
    logic match;
    logic ae;
    logic abe;
    logic af;
    logic wf;
    logic flags_hold;

    assign cur_fields = {cur_date, cur_hour, cur_min, cur_sec};

    alarm_match #(.DW(DW)) u_match (
        .alm_fields (alm_fields),
        .cur_fields (cur_fields),
        .match      (match)
    );

    alarm_regs #(.DW(DW), .AW(AW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_active  (acc_active),
        .acc_wr      (acc_wr),
        .acc_addr    (acc_addr),
        .acc_wdata   (acc_wdata),
        .backup      (backup),
        .bat_low     (bat_low),
        .tick        (tick),
        .match       (match),
        .wdog_expire (wdog_expire),
        .rdata       (acc_rdata),
        .alm_fields  (alm_fields),
        .ae          (ae),
        .abe         (abe),
        .af          (af),
        .wf          (wf),
        .flags_hold  (flags_hold)
    );

    irq_combine u_irq (
        .af         (af),
        .ae         (ae),
        .abe        (abe),
        .backup     (backup),
        .wf         (wf),
        .wds        (wds),
        .ft_en      (ft_en),
        .wdog_zero  (wdog_zero),
        .osc_512    (osc_512),
        .flags_hold (flags_hold),
        .irq_od_n   (irq_od_n)
    );

endmodule

// File: rtl/alarm_irq_chk.sv
// alarm_irq_chk: property checker for alarm_irq_unit, attached by bind.
module alarm_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       match,
    input logic       acc_active,
    input logic [3:0] acc_addr,
    input logic [7:0] acc_rdata,
    input logic       backup,
    input logic       ft_en,
    input logic       wdog_expire,
    input logic       ae,
    input logic       af,
    input logic       wf,
    input logic       irq_od_n
);

    // R1
    quiet_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ae && !ft_en && !wf) |-> irq_od_n);

    // R4
    af_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(af) |-> $past(tick));

    // R6
    flags_zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_addr == 4'h0) |-> (acc_rdata[5] == 1'b0 && acc_rdata[3:0] == 4'h0));

    // R7
    flags_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_active && !backup && acc_addr == 4'h0 && !ft_en) |-> irq_od_n);

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && match) |=> af);

    // R9
    wf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_expire |=> wf);

    // R11
    backup_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        backup |=> $stable(ae));

endmodule

bind alarm_irq_unit alarm_irq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .match       (match),
    .acc_active  (acc_active),
    .acc_addr    (acc_addr),
    .acc_rdata   (acc_rdata),
    .backup      (backup),
    .ft_en       (ft_en),
    .wdog_expire (wdog_expire),
    .ae          (ae),
    .af          (af),
    .wf          (wf),
    .irq_od_n    (irq_od_n)
);

// File: tb/sim_alarm_irq_unit.sv
// sim_alarm_irq_unit: directed corner cases plus seeded random alarm rounds.
module sim_alarm_irq_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] cur_sec = '0, cur_min = '0, cur_hour = '0, cur_date = '0;
    logic       acc_active = 1'b0, acc_wr = 1'b0;
    logic [3:0] acc_addr = 4'hF;
    logic [7:0] acc_wdata = '0;
    logic [7:0] acc_rdata;
    logic       backup = 1'b0, bat_low = 1'b0, wdog_expire = 1'b0;
    logic       wds = 1'b0, wdog_zero = 1'b0, ft_en = 1'b0, osc_512 = 1'b0;
    logic       irq_od_n;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    alarm_irq_unit u0 (.*);

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        acc_active = 1'b1; acc_wr = 1'b1; acc_addr = a; acc_wdata = d;
        @(negedge clk);
        acc_active = 1'b0; acc_wr = 1'b0; acc_addr = 4'hF;
    endtask

    task automatic do_read(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        acc_active = 1'b1; acc_wr = 1'b0; acc_addr = a;
        #1 d = acc_rdata;
        @(negedge clk);
        acc_active = 1'b0; acc_addr = 4'hF;
        @(negedge clk);
    endtask

    task automatic do_tick(input logic [7:0] s, m, h, d);
        @(negedge clk);
        cur_sec = s; cur_min = m; cur_hour = h; cur_date = d; tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic set_alarm(input logic [7:0] s, m, h, d);
        do_write(4'h2, s); do_write(4'h3, m); do_write(4'h4, h); do_write(4'h5, d);
    endtask

    function automatic logic [7:0] to_bcd(input int v);
        return 8'((v / 10) * 16 + (v % 10));
    endfunction

    // Bench model of the alarm rate table, from the requirements.
    function automatic bit exp_match(input logic [7:0] as, am, ah, ad,
                                     input logic [7:0] cs, cm, ch, cd);
        bit es = (as[6:0] == cs[6:0]);
        bit em = (am[6:0] == cm[6:0]);
        bit eh = (ah[5:0] == ch[5:0]);
        bit ed = (ad[5:0] == cd[5:0]);
        case ({ad[7], ah[7], am[7], as[7]})
            4'b1110: return es;
            4'b1100: return es && em;
            4'b1000: return es && em && eh;
            4'b0000: return es && em && eh && ed;
            default: return 1'b1;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 pin released", irq_od_n, 1);
        do_read(4'h0, rd); check("R1 flags", rd, 8'h00);
        do_read(4'h6, rd); check("R1 ctl", rd, 8'h00);

        // R4 matching time without tick sets nothing
        set_alarm(8'h80, 8'h80, 8'h80, 8'h80);
        repeat (5) @(negedge clk);
        do_read(4'h0, rd); check("R4 no tick", rd[6], 0);
        do_tick(8'h00, 8'h00, 8'h00, 8'h01);
        do_read(4'h0, rd); check("R4 tick sets AF", rd[6], 1);

        // R5 alarm drives the pin with AE, backup needs ABE
        do_write(4'h6, 8'h80);
        do_tick(8'h01, 8'h00, 8'h00, 8'h01);
        #1 check("R5 alarm pin", irq_od_n, 0);
        backup = 1'b1; #1 check("R5 backup no ABE", irq_od_n, 1);
        backup = 1'b0;
        do_write(4'h6, 8'hA0);
        backup = 1'b1; #1 check("R5 backup with ABE", irq_od_n, 0);

        // R11 accesses in backup are ignored
        do_write(4'h6, 8'h00);
        do_read(4'h0, rd);
        backup = 1'b0; #1 check("R11 no effect in backup", irq_od_n, 0);

        // R7 flag access masks the pin, then clears the flags
        @(negedge clk);
        acc_active = 1'b1; acc_addr = 4'h0;
        #1 check("R7 masked during access", irq_od_n, 1);
        check("R7 AF still visible", acc_rdata[6], 1);
        @(negedge clk);
        acc_active = 1'b0; acc_addr = 4'hF;
        @(negedge clk);
        check("R7 pin after clear", irq_od_n, 1);
        do_read(4'h0, rd); check("R7 AF cleared", rd[6], 0);

        // R8 matching tick on the clearing edge keeps AF
        @(negedge clk);
        acc_active = 1'b1; acc_addr = 4'h0;
        @(negedge clk);
        acc_active = 1'b0; acc_addr = 4'hF; tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        do_read(4'h0, rd); check("R8 set wins", rd[6], 1);

        // R12 register storage and unmapped reads
        do_read(4'h6, rd); check("R12 ctl readback", rd, 8'hA0);
        do_write(4'h6, 8'h5F);
        do_read(4'h6, rd); check("R12 ctl all bits", rd, 8'h5F);
        do_read(4'h2, rd); check("R12 alarm readback", rd, 8'h80);
        do_read(4'h1, rd); check("R12 unmapped", rd, 8'h00);
        do_write(4'h6, 8'h00);

        // R6 flag register layout and write immunity
        bat_low = 1'b1;
        do_read(4'h0, rd); check("R6 flags layout", rd, 8'h10);
        do_write(4'h0, 8'hFF);
        do_read(4'h0, rd); check("R6 write ignored", rd, 8'h10);
        bat_low = 1'b0;

        // R3 illegal mask pattern 0101 fires on a mismatching time
        set_alarm(8'h90, 8'h20, 8'h85, 8'h07);
        do_tick(8'h44, 8'h33, 8'h12, 8'h21);
        do_read(4'h0, rd); check("R3 illegal mask", rd[6], 1);

        // R2 seconds-only match
        set_alarm(8'h30, 8'h80, 8'h80, 8'h80);
        do_tick(8'h31, 8'h00, 8'h00, 8'h01);
        do_read(4'h0, rd); check("R2 seconds miss", rd[6], 0);
        do_tick(8'h30, 8'h12, 8'h05, 8'h09);
        do_read(4'h0, rd); check("R2 seconds hit", rd[6], 1);

        // R9 watchdog flag and steering
        @(negedge clk); wdog_expire = 1'b1;
        @(negedge clk); wdog_expire = 1'b0;
        #1 check("R9 watchdog pin", irq_od_n, 0);
        wds = 1'b1; #1 check("R9 steered away", irq_od_n, 1);
        do_read(4'h0, rd); check("R9 WF set", rd[7], 1);
        do_read(4'h0, rd); check("R9 WF cleared", rd[7], 0);

        // R2 R3 random rounds against the bench model
        for (int n = 0; n < 150; n++) begin
            logic [7:0] as, am, ah, ad, cs, cm, ch, cd;
            logic [3:0] msk;
            bit em;
            msk = 4'($urandom % 16);
            as = {msk[0], 7'(to_bcd($urandom % 60))};
            am = {msk[1], 7'(to_bcd($urandom % 60))};
            ah = {msk[2], 7'(to_bcd($urandom % 24))};
            ad = {msk[3], 7'(to_bcd(1 + $urandom % 31))};
            cs = {1'b0, as[6:0]}; cm = {1'b0, am[6:0]};
            ch = {2'b00, ah[5:0]}; cd = {2'b00, ad[5:0]};
            if ($urandom % 3 == 0) cs = to_bcd($urandom % 60);
            if ($urandom % 3 == 0) cm = to_bcd($urandom % 60);
            if ($urandom % 3 == 0) ch = to_bcd($urandom % 24);
            if ($urandom % 3 == 0) cd = to_bcd(1 + $urandom % 31);
            em = exp_match(as, am, ah, ad, cs, cm, ch, cd);
            set_alarm(as, am, ah, ad);
            do_tick(cs, cm, ch, cd);
            do_read(4'h0, rd);
            check($sformatf("R2 random round %0d mask %b", n, msk), rd[6], em);
        end

        // R10 frequency test source
        ft_en = 1'b1; wds = 1'b1;
        osc_512 = 1'b1; #1 check("R10 follows high", irq_od_n, 0);
        osc_512 = 1'b0; #1 check("R10 follows low", irq_od_n, 1);
        wds = 1'b0; wdog_zero = 1'b0; osc_512 = 1'b1;
        #1 check("R10 off when watchdog active", irq_od_n, 1);
        wdog_zero = 1'b1; #1 check("R10 on with zero watchdog", irq_od_n, 0);
        do_write(4'h6, 8'h80);
        #1 check("R10 off with AE", irq_od_n, 1);
        ft_en = 1'b0; osc_512 = 1'b0;

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule